// File: doc/BRIEF.md
# Accumulator Arithmetic Unit with Condition Flags

This block performs the byte-wide arithmetic of a small accumulator processor. It offers addition, addition with carry, subtraction, subtraction with borrow, compare, and decimal adjustment of a packed BCD byte. The processor supplies the current accumulator, a second operand byte and the four stored condition flags: zero, subtract, half-carry and carry.

When the strobe `op_go` is high, the new accumulator value and all four flags are captured together on the same rising clock edge. `acc_wr` then pulses for one cycle to tell the register file that the accumulator must be written. Compare sets the flags but never writes the accumulator. Decimal adjust uses the stored subtract, half-carry and carry flags to correct the byte after an earlier BCD add or subtract.

Top module: `acc_alu_flags`

## Requirements
- R1: Operation select codes are 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 compare and 5 decimal adjust. Add and add-with-carry produce (A + B + cin) mod 256 and clear the subtract flag. The carry-in `cin` is `flg_c_in` for add-with-carry and 0 for add.
- R2: Subtract and subtract-with-borrow produce (A - B - cin) mod 256. The carry-in `cin` is `flg_c_in` for subtract-with-borrow and 0 for subtract. These two operations and compare set the subtract flag.
- R3: After every accepted operation, the zero flag is 1 exactly when the 8-bit wrapped result is 0x00. For compare, the result is A - B.
- R4: Half-carry is set when the low-nibble sum, including carry-in, exceeds 0xF for add and add-with-carry. For subtract, subtract-with-borrow and compare, it is set when the low nibble of A is less than the low nibble of B plus the carry-in.
- R5: Carry is set when A + B + cin exceeds 0xFF for add and add-with-carry. For subtract, subtract-with-borrow and compare, it is set when A < B + cin.
- R6: Compare updates all four flags, leaves `acc_out` unchanged and keeps `acc_wr` low.
- R7: Decimal adjust with stored subtract flag 0 does two steps in order. First it adds 0x06 when the stored half-carry is 1 or the low nibble of A exceeds 9. Then it adds 0x60 when the stored carry is 1 or the partial value exceeds 0x9F. The result wraps mod 256.
- R8: Decimal adjust with stored subtract flag 1 subtracts 0x06 when the stored half-carry is 1 and subtracts 0x60 when the stored carry is 1. No range checks are made.
- R9: After decimal adjust, half-carry is 0 and the subtract flag keeps its stored value. Carry is 1 when the 0x60 correction was applied or the stored carry was 1.
- R10: Results and flags change only on a rising edge where `op_go` is high. `acc_wr` is high for exactly the one cycle after such an edge, and only when the operation writes the accumulator.
- R11: Codes 6 and 7 are reserved. With `op_go` high they change no output and keep `acc_wr` low.
- R12: While `rst_n` is low, `acc_out` is 0x00 and all flags and `acc_wr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_go | input | 1 | Accept the operation on this edge |
| op_sel | input | 3 | Operation code (see R1) |
| acc_in | input | 8 | Current accumulator value |
| opnd_in | input | 8 | Second operand |
| flg_z_in | input | 1 | Stored zero flag |
| flg_n_in | input | 1 | Stored subtract flag |
| flg_h_in | input | 1 | Stored half-carry flag |
| flg_c_in | input | 1 | Stored carry flag |
| acc_out | output | 8 | Registered accumulator result |
| acc_wr | output | 1 | One-cycle accumulator write pulse |
| flg_z | output | 1 | Updated zero flag |
| flg_n | output | 1 | Updated subtract flag |
| flg_h | output | 1 | Updated half-carry flag |
| flg_c | output | 1 | Updated carry flag |

## Verification
Each result, each flag and the write pulse is due exactly one rising edge after the strobe that carries the operation. Nothing in the block adds further latency.

The bench sets its inputs and raises `op_go` on a falling edge. It then waits one full clock period and samples the outputs on the next falling edge, so every comparison falls half a period after the capturing edge. Hold behaviour, compare and the reserved codes are checked in the same cycle. The strobe-free cycle that follows is used to confirm that `acc_wr` has dropped and that nothing has moved.

// File: rtl/acc_alu_flags.sv
`timescale 1ns/1ps
module acc_alu_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_go,
  input  logic [2:0] op_sel,
  input  logic [7:0] acc_in,
  input  logic [7:0] opnd_in,
  input  logic       flg_z_in,
  input  logic       flg_n_in,
  input  logic       flg_h_in,
  input  logic       flg_c_in,
  output logic [7:0] acc_out,
  output logic       acc_wr,
  output logic       flg_z,
  output logic       flg_n,
  output logic       flg_h,
  output logic       flg_c
);
  localparam int DW = 8;
  localparam int NW = DW / 2;
  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_ADC = 3'd1;
  localparam logic [2:0] OP_SUB = 3'd2;
  localparam logic [2:0] OP_SBC = 3'd3;
  localparam logic [2:0] OP_CP  = 3'd4;
  localparam logic [2:0] OP_DAA = 3'd5;

  logic          is_sub, is_daa, op_ok, use_c, cin;
  logic [DW-1:0] bx;
  logic [NW:0]   lo_sum, hi_sum;
  logic [DW-1:0] ar_res;
  logic          ar_h, ar_c;

  assign is_sub = (op_sel == OP_SUB) || (op_sel == OP_SBC) || (op_sel == OP_CP);
  assign is_daa = (op_sel == OP_DAA);
  assign op_ok  = (op_sel <= OP_DAA);
  assign use_c  = ((op_sel == OP_ADC) || (op_sel == OP_SBC)) && flg_c_in;
  assign bx     = is_sub ? ~opnd_in : opnd_in;
  assign cin    = is_sub ? ~use_c : use_c;

  assign lo_sum = {1'b0, acc_in[NW-1:0]} + {1'b0, bx[NW-1:0]} + {{NW{1'b0}}, cin};
  assign hi_sum = {1'b0, acc_in[DW-1:NW]} + {1'b0, bx[DW-1:NW]} + {{NW{1'b0}}, lo_sum[NW]};
  assign ar_res = {hi_sum[NW-1:0], lo_sum[NW-1:0]};
  assign ar_h   = is_sub ? ~lo_sum[NW] : lo_sum[NW];
  assign ar_c   = is_sub ? ~hi_sum[NW] : hi_sum[NW];

  logic          lo_fix, hi_fix;
  logic [DW:0]   da_part;
  logic [DW-1:0] da_add, da_sub, da_res;
  logic          da_c;

  assign lo_fix  = flg_h_in || (acc_in[NW-1:0] > 4'd9);
  assign da_part = {1'b0, acc_in} + (lo_fix ? 9'h006 : 9'h000);
  assign hi_fix  = flg_c_in || (da_part > 9'h09F);
  assign da_add  = da_part[DW-1:0] + (hi_fix ? 8'h60 : 8'h00);
  assign da_sub  = acc_in - (flg_h_in ? 8'h06 : 8'h00) - (flg_c_in ? 8'h60 : 8'h00);
  assign da_res  = flg_n_in ? da_sub : da_add;
  assign da_c    = flg_n_in ? flg_c_in : hi_fix;

  logic [DW-1:0] res;
  assign res = is_daa ? da_res : ar_res;

  logic unused_z;
  assign unused_z = flg_z_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_out <= '0;
      acc_wr  <= 1'b0;
      flg_z   <= 1'b0;
      flg_n   <= 1'b0;
      flg_h   <= 1'b0;
      flg_c   <= 1'b0;
    end else begin
      acc_wr <= op_go && op_ok && (op_sel != OP_CP);
      if (op_go && op_ok) begin
        flg_z <= (res == '0);
        flg_n <= is_daa ? flg_n_in : is_sub;
        flg_h <= is_daa ? 1'b0 : ar_h;
        flg_c <= is_daa ? da_c : ar_c;
        if (op_sel != OP_CP) acc_out <= res;
      end
    end
  end

  assert_add_clears_n_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_go && (op_sel == OP_ADD || op_sel == OP_ADC)) |=> !flg_n);

  assert_sub_sets_n_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_go && (op_sel == OP_SUB || op_sel == OP_SBC || op_sel == OP_CP)) |=> flg_n);

  assert_zero_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_go && op_sel <= OP_DAA && op_sel != OP_CP) |=> (flg_z == (acc_out == 8'h00)));

  assert_cp_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_go && op_sel == OP_CP) |=> (!acc_wr && $stable(acc_out)));

  assert_daa_h_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_go && op_sel == OP_DAA) |=> !flg_h);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !op_go |=> (!acc_wr && $stable(acc_out) && $stable({flg_z, flg_n, flg_h, flg_c})));

  assert_reserved_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_go && op_sel > OP_DAA) |=> (!acc_wr && $stable(acc_out) && $stable({flg_z, flg_n, flg_h, flg_c})));
endmodule

// File: tb/acc_alu_flags_tb.sv
`timescale 1ns/1ps
module acc_alu_flags_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_go = 1'b0;
  logic [2:0] op_sel = '0;
  logic [7:0] acc_in = '0, opnd_in = '0;
  logic fz = 1'b0, fn = 1'b0, fh = 1'b0, fc = 1'b0;
  logic [7:0] acc_out;
  logic acc_wr, flg_z, flg_n, flg_h, flg_c;
  int checks = 0;
  int fails = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  acc_alu_flags dut_i (
    .clk(clk), .rst_n(rst_n), .op_go(op_go), .op_sel(op_sel),
    .acc_in(acc_in), .opnd_in(opnd_in),
    .flg_z_in(fz), .flg_n_in(fn), .flg_h_in(fh), .flg_c_in(fc),
    .acc_out(acc_out), .acc_wr(acc_wr),
    .flg_z(flg_z), .flg_n(flg_n), .flg_h(flg_h), .flg_c(flg_c)
  );

  // {op, A, B, flags_in ZNHC, result, flags_out ZNHC}
  localparam logic [34:0] VEC [14] = '{
    {3'd0, 8'h3A, 8'hC6, 4'b0000, 8'h00, 4'b1011},
    {3'd0, 8'h0F, 8'h01, 4'b0000, 8'h10, 4'b0010},
    {3'd1, 8'hE1, 8'h0F, 4'b0001, 8'hF1, 4'b0010},
    {3'd1, 8'hFF, 8'h00, 4'b0001, 8'h00, 4'b1011},
    {3'd2, 8'h3E, 8'h3E, 4'b0000, 8'h00, 4'b1100},
    {3'd2, 8'h3E, 8'h0F, 4'b0000, 8'h2F, 4'b0110},
    {3'd3, 8'h3B, 8'h2A, 4'b0001, 8'h10, 4'b0100},
    {3'd3, 8'h00, 8'h00, 4'b0001, 8'hFF, 4'b0111},
    {3'd5, 8'h7D, 8'h00, 4'b0000, 8'h83, 4'b0000},
    {3'd5, 8'h9A, 8'h00, 4'b0000, 8'h00, 4'b1001},
    {3'd5, 8'h0F, 8'h00, 4'b0110, 8'h09, 4'b0100},
    {3'd5, 8'h00, 8'h00, 4'b0111, 8'h9A, 4'b0101},
    {3'd5, 8'h00, 8'h00, 4'b0001, 8'h60, 4'b0001},
    {3'd5, 8'h10, 8'h00, 4'b0010, 8'h16, 4'b0000}
  };

  function automatic logic [11:0] ref_op(input int op, input int a, input int b, input logic [3:0] f);
    int ci, r, h, cy, n;
    logic [7:0] r8;
    ci = 0; r = 0; h = 0; cy = 0; n = 0;
    if (op <= 1) begin
      ci = (op == 1) ? int'(f[0]) : 0;
      r = a + b + ci;
      h = (((a % 16) + (b % 16) + ci) > 15) ? 1 : 0;
      cy = (r > 255) ? 1 : 0;
      n = 0;
    end else if (op <= 4) begin
      ci = (op == 3) ? int'(f[0]) : 0;
      r = a - b - ci + 512;
      h = ((a % 16) < (b % 16) + ci) ? 1 : 0;
      cy = (a < b + ci) ? 1 : 0;
      n = 1;
    end else begin
      r = a;
      if (!f[2]) begin
        if (f[1] || (a % 16) > 9) r = r + 6;
        if (f[0] || r > 'h9F) begin r = r + 'h60; cy = 1; end
      end else begin
        if (f[1]) r = r - 6 + 256;
        if (f[0]) r = r - 'h60 + 256;
        cy = int'(f[0]);
      end
      h = 0;
      n = int'(f[2]);
    end
    r8 = 8'(r % 256);
    return {r8, (r8 == 8'h00), n[0], h[0], cy[0]};
  endfunction

  task automatic check(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b, input logic [3:0] f);
    op_sel = op; acc_in = a; opnd_in = b;
    {fz, fn, fh, fc} = f;
    op_go = 1'b1;
    @(negedge clk);
    op_go = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] exp_acc;
    logic [11:0] e;
    logic [7:0] hold_acc;
    logic [3:0] hold_f;

    repeat (3) @(negedge clk);
    check("R12", "acc_out in reset", int'(acc_out), 0);
    check("R12", "flags in reset", int'({flg_z, flg_n, flg_h, flg_c}), 0);
    check("R12", "acc_wr in reset", int'(acc_wr), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 14; i++) begin
      run_op(VEC[i][34:32], VEC[i][31:24], VEC[i][23:16], VEC[i][15:12]);
      check("R1 R2 R7 R8", "table result", int'(acc_out), int'(VEC[i][11:4]));
      check("R3 R4 R5 R9", "table flags", int'({flg_z, flg_n, flg_h, flg_c}), int'(VEC[i][3:0]));
      check("R10", "table acc_wr", int'(acc_wr), 1);
    end

    // R10: idle cycle drops the pulse and holds everything
    hold_acc = acc_out; hold_f = {flg_z, flg_n, flg_h, flg_c};
    acc_in = 8'hAA; opnd_in = 8'h55; op_sel = 3'd0;
    @(negedge clk);
    check("R10", "idle acc_wr", int'(acc_wr), 0);
    check("R10", "idle acc_out", int'(acc_out), int'(hold_acc));
    check("R10", "idle flags", int'({flg_z, flg_n, flg_h, flg_c}), int'(hold_f));

    // R6: compare leaves the accumulator alone
    run_op(3'd0, 8'h20, 8'h05, 4'b0000);
    check("R1", "preload", int'(acc_out), 'h25);
    run_op(3'd4, 8'h25, 8'h25, 4'b0001);
    check("R6", "cp acc_out", int'(acc_out), 'h25);
    check("R6", "cp acc_wr", int'(acc_wr), 0);
    check("R6", "cp flags equal", int'({flg_z, flg_n, flg_h, flg_c}), 'b1100);
    run_op(3'd4, 8'h3C, 8'h40, 4'b0000);
    check("R6", "cp flags below", int'({flg_z, flg_n, flg_h, flg_c}), 'b0101);
    check("R6", "cp acc_out kept", int'(acc_out), 'h25);

    // R11: reserved codes
    for (int k = 6; k < 8; k++) begin
      hold_acc = acc_out; hold_f = {flg_z, flg_n, flg_h, flg_c};
      run_op(3'(k), 8'h00, 8'h00, 4'b0000);
      check("R11", "reserved acc_out", int'(acc_out), int'(hold_acc));
      check("R11", "reserved flags", int'({flg_z, flg_n, flg_h, flg_c}), int'(hold_f));
      check("R11", "reserved acc_wr", int'(acc_wr), 0);
    end

    // R1..R5 sweep against the model
    exp_acc = acc_out;
    for (int op = 0; op < 5; op++) begin
      for (int a = 0; a < 256; a++) begin
        for (int bi = 0; bi < 16; bi++) begin
          for (int c = 0; c < 2; c++) begin
            int b;
            logic [3:0] f;
            b = (bi * 37 + a * 3 + bi * bi) % 256;
            f = {a[0], a[1], bi[0], c[0]};
            run_op(3'(op), 8'(a), 8'(b), f);
            e = ref_op(op, a, b, f);
            if (op != 4) exp_acc = e[11:4];
            check("R1 R2", "sweep result", int'(acc_out), int'(exp_acc));
            check("R3 R4 R5", "sweep flags", int'({flg_z, flg_n, flg_h, flg_c}), int'(e[3:0]));
          end
        end
      end
    end

    // R7 R8 R9 sweep of decimal adjust
    for (int a = 0; a < 256; a++) begin
      for (int f = 0; f < 8; f++) begin
        run_op(3'd5, 8'(a), 8'h00, {1'b0, 3'(f)});
        e = ref_op(5, a, 0, {1'b0, 3'(f)});
        check("R7 R8", "daa result", int'(acc_out), int'(e[11:4]));
        check("R9", "daa flags", int'({flg_z, flg_n, flg_h, flg_c}), int'(e[3:0]));
      end
    end

    // R12: reset in the middle of a run
    run_op(3'd0, 8'h01, 8'h01, 4'b0000);
    rst_n = 1'b0;
    @(negedge clk);
    check("R12", "reset acc_out", int'(acc_out), 0);
    check("R12", "reset flags", int'({flg_z, flg_n, flg_h, flg_c}), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule